// File: doc/BRIEF.md
# DMA Channel Event and Interrupt Status Unit

This block gathers per-channel completion and fault events from a set of DMA channel engines and holds them in sticky status registers. Software reads them over a simple word-addressed register port and clears them by writing ones. A completion flag register has one bit per channel. Four fault classes each have their own flag register: burst overrun, request timeout, transfer fault and buffer overflow. A per-channel interrupt mask selects which channels may raise the two interrupt lines. One line signals completion and the other signals faults.

The burst overrun class is generated inside the block. Each channel has a watchdog counter that starts from zero when the channel's burst-active level goes high. If the burst is still active when the counter reaches a programmed limit, the counter flags that channel. A global control register enables event capture. Writing its reset bit puts all status flags and masks back to their idle values.

Top module: `dma_evt_status`

## Requirements
- R1: After `rst_n` is released, reading gives the following values: control 0 (capture disabled), all flag registers 0, mask all ones, and watchdog configuration 0. Both `irq_done` and `irq_err` are low.
- R2: Word addresses are 0 control, 1 completion flags, 2 mask, 3 burst overrun flags, 4 request timeout flags, 5 transfer fault flags, 6 buffer overflow flags and 7 watchdog configuration. In every flag and mask register, bit i belongs to channel i, and unused upper read bits are 0.
- R3: While capture is enabled, a one-cycle pulse on channel i of an event input sets bit i of that class's flag register at the next clock edge. While capture is disabled, event inputs change no flag register.
- R4: Any fault event on channel i (any of the four classes) also sets bit i of the completion flags.
- R5: Writing a flag register clears every bit written as 1 and leaves every bit written as 0 unchanged. The completion register and each fault register are cleared independently of one another.
- R6: If an event for a bit arrives in the same cycle as a write-1 clear of that bit, the bit stays set.
- R7: `irq_done` is high exactly when some channel has its completion flag set and its mask bit 0.
- R8: `irq_err` is high exactly when some channel with mask bit 0 has at least one of its four fault flags set.
- R9: In the watchdog configuration register, bit 15 arms the watchdog and bits 14:0 hold a limit L. When armed, a channel whose `burst_busy` is sampled high on L+1 consecutive clock edges gets its burst overrun flag set at the (L+1)th edge. A shorter burst does not set it. A flag is raised at most once per burst, and nothing is raised while the watchdog is unarmed.
- R10: A write to control loads bit 0 as the capture enable. If bit 1 of that write is 1, the same edge clears all flag registers and sets all mask bits, and this overrides any event arriving in that cycle. The watchdog configuration is kept, and control bit 1 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 16 | Register read data (combinational) |
| evt_done | input | NCH | Per-channel completion pulses |
| evt_req_to | input | NCH | Per-channel request timeout pulses |
| evt_xfer_err | input | NCH | Per-channel transfer fault pulses |
| evt_ovf | input | NCH | Per-channel buffer overflow pulses |
| burst_busy | input | NCH | Per-channel level, high while a burst is in progress |
| irq_done | output | 1 | Completion interrupt |
| irq_err | output | 1 | Fault interrupt |

## Verification
On every cycle, the bound checker checks four things. Enabled events land in their flag registers, and fault events also land in the completion flags. Flags stay put while capture is disabled and nothing is written. A soft reset leaves cleared flags and a full mask, and a fully masked unit raises no interrupt. The bench scenarios show what a cycle-local property cannot. These are the exact interrupt function across every flag and mask pattern of a four-channel unit, the write-one-clear and event-wins races, and the edge at which the burst watchdog fires relative to the programmed limit. The scenarios also show that the watchdog fires only once per burst and that the configuration survives a soft reset.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;
   localparam int REG_W  = 16;
   localparam int ADDR_W = 3;
   localparam int N_ERR  = 4;
   localparam int LIM_W  = 15;

   typedef enum logic [ADDR_W-1:0] {
      A_CTRL    = 3'd0,
      A_DONE    = 3'd1,
      A_MASK    = 3'd2,
      A_ERR_BTO = 3'd3,
      A_ERR_REQ = 3'd4,
      A_ERR_XFR = 3'd5,
      A_ERR_OVF = 3'd6,
      A_BTO_CFG = 3'd7
   } reg_addr_e;

   localparam int CLS_BTO = 0;
   localparam int CLS_REQ = 1;
   localparam int CLS_XFR = 2;
   localparam int CLS_OVF = 3;
endpackage

// File: rtl/dma_w1c_bank.sv
module dma_w1c_bank #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sclr,
   input  logic [W-1:0] set,
   input  logic [W-1:0] clr,
   output logic [W-1:0] q
);
   // set dominates clr; sclr dominates both
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (sclr)  q <= '0;
      else            q <= (q & ~clr) | set;
   end
endmodule

// File: rtl/dma_burst_watchdog.sv
module dma_burst_watchdog #(
   parameter int LW = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          busy,
   input  logic          arm,
   input  logic [LW-1:0] limit,
   output logic          expire
);
   logic [LW-1:0] cnt_q;
   logic          fired_q;

   assign expire = arm && busy && !fired_q && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         fired_q <= 1'b0;
      end else if (!busy) begin
         cnt_q   <= '0;
         fired_q <= 1'b0;
      end else if (expire) begin
         fired_q <= 1'b1;
      end else if (!fired_q && (cnt_q != {LW{1'b1}})) begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/dma_irq_merge.sv
module dma_irq_merge #(
   parameter int NCH  = 8,
   parameter int NCLS = 4
) (
   input  logic [NCH-1:0]           done,
   input  logic [NCH-1:0]           mask,
   input  logic [NCLS-1:0][NCH-1:0] err,
   output logic                     irq_done,
   output logic                     irq_err
);
   logic [NCH-1:0] err_flag;

   always_comb begin
      err_flag = '0;
      for (int k = 0; k < NCLS; k++) err_flag = err_flag | err[k];
   end

   assign irq_done = |(done & ~mask);
   assign irq_err  = |(err_flag & ~mask);
endmodule

// File: rtl/dma_evt_status.sv
module dma_evt_status
   import dma_evt_pkg::*;
#(
   parameter int NCH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [REG_W-1:0]  rd_data,
   input  logic [NCH-1:0]    evt_done,
   input  logic [NCH-1:0]    evt_req_to,
   input  logic [NCH-1:0]    evt_xfer_err,
   input  logic [NCH-1:0]    evt_ovf,
   input  logic [NCH-1:0]    burst_busy,
   output logic              irq_done,
   output logic              irq_err
);
   localparam int ERR_BASE = int'(A_ERR_BTO);

   generate
      if (NCH < 1 || NCH > REG_W) begin : g_bad_nch
         $error("dma_evt_status: NCH must be within 1..16");
      end
   endgenerate

   logic                       en_q;
   logic [NCH-1:0]             mask_q;
   logic                       bto_arm_q;
   logic [LIM_W-1:0]           bto_lim_q;
   logic [NCH-1:0]             done_q;
   logic [N_ERR-1:0][NCH-1:0]  err_q;
   logic [N_ERR-1:0][NCH-1:0]  err_evt;
   logic [NCH-1:0]             bto_evt;
   logic [NCH-1:0]             err_any_evt;
   logic [NCH-1:0]             done_set;
   logic [NCH-1:0]             done_clr;
   logic                       soft_rst;

   assign soft_rst = wr_en && (wr_addr == A_CTRL) && wr_data[1];

   // control, mask and watchdog configuration
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         mask_q    <= '1;
         bto_arm_q <= 1'b0;
         bto_lim_q <= '0;
      end else begin
         if (wr_en && wr_addr == A_CTRL) en_q <= wr_data[0];
         if (soft_rst)
            mask_q <= '1;
         else if (wr_en && wr_addr == A_MASK)
            mask_q <= wr_data[NCH-1:0];
         if (wr_en && wr_addr == A_BTO_CFG) begin
            bto_arm_q <= wr_data[REG_W-1];
            bto_lim_q <= wr_data[LIM_W-1:0];
         end
      end
   end

   // per-channel burst watchdogs
   generate
      for (genvar c = 0; c < NCH; c++) begin : g_wdog
         dma_burst_watchdog #(.LW(LIM_W)) u_wd (
            .clk    (clk),
            .rst_n  (rst_n),
            .busy   (burst_busy[c]),
            .arm    (bto_arm_q),
            .limit  (bto_lim_q),
            .expire (bto_evt[c])
         );
      end
   endgenerate

   assign err_evt[CLS_BTO] = bto_evt;
   assign err_evt[CLS_REQ] = evt_req_to;
   assign err_evt[CLS_XFR] = evt_xfer_err;
   assign err_evt[CLS_OVF] = evt_ovf;

   always_comb begin
      err_any_evt = '0;
      for (int k = 0; k < N_ERR; k++) err_any_evt = err_any_evt | err_evt[k];
   end

   // fault flag banks, one per class
   generate
      for (genvar k = 0; k < N_ERR; k++) begin : g_err
         logic [NCH-1:0] set_k;
         logic [NCH-1:0] clr_k;
         assign set_k = en_q ? err_evt[k] : '0;
         assign clr_k = (wr_en && int'(wr_addr) == ERR_BASE + k) ? wr_data[NCH-1:0] : '0;
         dma_w1c_bank #(.W(NCH)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .sclr  (soft_rst),
            .set   (set_k),
            .clr   (clr_k),
            .q     (err_q[k])
         );
      end
   endgenerate

   // completion flag bank
   assign done_set = en_q ? (evt_done | err_any_evt) : '0;
   assign done_clr = (wr_en && wr_addr == A_DONE) ? wr_data[NCH-1:0] : '0;

   dma_w1c_bank #(.W(NCH)) u_done (
      .clk   (clk),
      .rst_n (rst_n),
      .sclr  (soft_rst),
      .set   (done_set),
      .clr   (done_clr),
      .q     (done_q)
   );

   dma_irq_merge #(.NCH(NCH), .NCLS(N_ERR)) u_irq (
      .done     (done_q),
      .mask     (mask_q),
      .err      (err_q),
      .irq_done (irq_done),
      .irq_err  (irq_err)
   );

   // read path
   always_comb begin
      rd_data = '0;
      case (rd_addr)
         A_CTRL:    rd_data[0]         = en_q;
         A_DONE:    rd_data[NCH-1:0]   = done_q;
         A_MASK:    rd_data[NCH-1:0]   = mask_q;
         A_ERR_BTO: rd_data[NCH-1:0]   = err_q[CLS_BTO];
         A_ERR_REQ: rd_data[NCH-1:0]   = err_q[CLS_REQ];
         A_ERR_XFR: rd_data[NCH-1:0]   = err_q[CLS_XFR];
         A_ERR_OVF: rd_data[NCH-1:0]   = err_q[CLS_OVF];
         A_BTO_CFG: rd_data            = {bto_arm_q, bto_lim_q};
         default:   rd_data            = '0;
      endcase
   end
endmodule

// File: rtl/dma_evt_status_chk.sv
module dma_evt_status_chk
   import dma_evt_pkg::*;
#(
   parameter int NCH = 8
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      wr_en,
   input logic                      soft_rst,
   input logic [NCH-1:0]            evt_done,
   input logic [NCH-1:0]            evt_req_to,
   input logic [NCH-1:0]            evt_xfer_err,
   input logic [NCH-1:0]            evt_ovf,
   input logic                      en_q,
   input logic [NCH-1:0]            mask_q,
   input logic [NCH-1:0]            done_q,
   input logic [N_ERR-1:0][NCH-1:0] err_q,
   input logic                      irq_done,
   input logic                      irq_err
);
   logic [NCH-1:0] ext_err;
   assign ext_err = evt_req_to | evt_xfer_err | evt_ovf;

   // R3
   done_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !soft_rst) |=> ((done_q & $past(evt_done)) == $past(evt_done)));

   // R3
   xfer_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !soft_rst) |=> ((err_q[CLS_XFR] & $past(evt_xfer_err)) == $past(evt_xfer_err)));

   // R4
   err_marks_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !soft_rst) |=> ((done_q & $past(ext_err)) == $past(ext_err)));

   // R3
   disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !wr_en) |=> ($stable(done_q) && $stable(err_q)));

   // R10
   soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (done_q == '0 && err_q == '0 && (&mask_q)));

   // R7
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_q) |-> (!irq_done && !irq_err));
endmodule

bind dma_evt_status dma_evt_status_chk #(.NCH(NCH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .soft_rst     (soft_rst),
   .evt_done     (evt_done),
   .evt_req_to   (evt_req_to),
   .evt_xfer_err (evt_xfer_err),
   .evt_ovf      (evt_ovf),
   .en_q         (en_q),
   .mask_q       (mask_q),
   .done_q       (done_q),
   .err_q        (err_q),
   .irq_done     (irq_done),
   .irq_err      (irq_err)
);

// File: tb/sim_dma_evt_status.sv
module sim_dma_evt_status;
   localparam int N = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_addr = '0;
   logic [15:0]   wr_data = '0;
   logic [2:0]    rd_addr = '0;
   logic [15:0]   rd_data;
   logic [N-1:0]  evt_done = '0, evt_req_to = '0, evt_xfer_err = '0, evt_ovf = '0;
   logic [N-1:0]  burst_busy = '0;
   logic          irq_done, irq_err;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   dma_evt_status #(.NCH(N)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .evt_done(evt_done), .evt_req_to(evt_req_to),
      .evt_xfer_err(evt_xfer_err), .evt_ovf(evt_ovf), .burst_busy(burst_busy),
      .irq_done(irq_done), .irq_err(irq_err)
   );

   task automatic check(input int act, input int exp, input string tag);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic rd(input int a, input int exp, input string tag);
      rd_addr = 3'(a);
      #1;
      check(int'(rd_data), exp, tag);
   endtask

   task automatic wr(input int a, input int d);
      wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse(input logic [N-1:0] d, r, x, o);
      evt_done = d; evt_req_to = r; evt_xfer_err = x; evt_ovf = o;
      @(negedge clk);
      evt_done = '0; evt_req_to = '0; evt_xfer_err = '0; evt_ovf = '0;
   endtask

   task automatic clear_all();
      for (int a = 3; a <= 6; a++) wr(a, 'hF);
      wr(1, 'hF);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 / R2 reset values per address
      for (int a = 0; a < 8; a++) rd(a, (a == 2) ? 'hF : 0, "R1 reset register");
      check(int'(irq_done), 0, "R1 irq_done reset");
      check(int'(irq_err), 0, "R1 irq_err reset");

      // R3 capture disabled: events ignored
      pulse('hF, 'hF, 'hF, 'hF);
      for (int a = 1; a <= 6; a++) if (a != 2) rd(a, 0, "R3 disabled capture");

      // R10 enable
      wr(0, 1);
      rd(0, 1, "R10 enable readback");

      // R3 / R4 each channel and source
      for (int ch = 0; ch < N; ch++) begin
         for (int src = 0; src < 4; src++) begin
            logic [N-1:0] b;
            b = N'(1 << ch);
            clear_all();
            pulse(src == 0 ? b : '0, src == 1 ? b : '0, src == 2 ? b : '0, src == 3 ? b : '0);
            rd(1, 1 << ch, "R4 completion flag per source");
            rd(3, 0, "R3 overrun untouched");
            for (int a = 4; a <= 6; a++)
               rd(a, (a - 3 == src) ? (1 << ch) : 0, "R3 class flag per channel");
         end
      end
      clear_all();

      // R7 completion interrupt over every flag/mask pattern
      for (int d = 0; d < 16; d++) begin
         for (int m = 0; m < 16; m++) begin
            wr(1, 'hF);
            pulse(N'(d), '0, '0, '0);
            wr(2, m);
            check(int'(irq_done), ((d & ~m & 'hF) != 0) ? 1 : 0, "R7 irq_done");
         end
      end

      // R8 fault interrupt over every flag/mask pattern
      for (int e = 0; e < 16; e++) begin
         for (int m = 0; m < 16; m++) begin
            wr(5, 'hF);
            pulse('0, '0, N'(e), '0);
            wr(2, m);
            check(int'(irq_err), ((e & ~m & 'hF) != 0) ? 1 : 0, "R8 irq_err");
         end
      end
      clear_all();
      wr(2, 0);

      // R5 / R8 independent clearing
      pulse('0, '0, 4'b0010, '0);
      wr(5, 'hF);
      check(int'(irq_err), 0, "R8 irq_err after fault clear");
      check(int'(irq_done), 1, "R5 completion kept after fault clear");
      rd(1, 'h2, "R5 completion independent");

      // R5 write-one-clear
      clear_all();
      pulse('hF, '0, '0, '0);
      wr(1, 0);
      rd(1, 'hF, "R5 write zero keeps");
      wr(1, 5);
      rd(1, 'hA, "R5 partial clear");
      wr(1, 'hA);
      rd(1, 0, "R5 full clear");

      // R6 event beats clear
      pulse(4'b0011, '0, '0, '0);
      evt_done = 4'b0001;
      wr(1, 'h3);
      evt_done = '0;
      rd(1, 'h1, "R6 event wins over clear");
      clear_all();

      // R9 burst watchdog, limit 3
      wr(7, 'h8003);
      rd(7, 'h8003, "R9 config readback");
      burst_busy[2] = 1'b1;
      repeat (3) @(negedge clk);
      burst_busy[2] = 1'b0;
      rd(3, 0, "R9 short burst no flag");
      @(negedge clk);
      burst_busy[2] = 1'b1;
      repeat (3) @(negedge clk);
      rd(3, 0, "R9 not before L+1 edges");
      @(negedge clk);
      rd(3, 'h4, "R9 flag at L+1 edges");
      rd(1, 'h4, "R4 overrun marks completion");
      wr(3, 'hF);
      repeat (6) @(negedge clk);
      rd(3, 0, "R9 once per burst");
      burst_busy[2] = 1'b0;
      @(negedge clk);
      clear_all();
      wr(7, 'h0003);
      burst_busy = '1;
      repeat (10) @(negedge clk);
      burst_busy = '0;
      rd(3, 0, "R9 unarmed no flag");

      // R10 soft reset
      wr(2, 0);
      pulse('hF, 'hF, '0, 'hF);
      wr(0, 2);
      rd(0, 0, "R10 enable cleared and reset bit reads 0");
      for (int a = 1; a <= 6; a++) rd(a, (a == 2) ? 'hF : 0, "R10 soft reset state");
      rd(7, 'h0003, "R10 config retained");
      pulse('hF, '0, '0, '0);
      rd(1, 0, "R10 disabled after soft reset");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule